// File: doc/BRIEF.md
# MDIO Management Master

This block lets software reach the management registers of an Ethernet PHY over a two-wire serial link: a management clock (MDC) and a bidirectional data line (MDIO). Software loads a PHY address and register number into an address register and, for a write, a 16-bit value into a write-data register. It then writes a command word that starts the transfer. The block shifts out a 64-bit Clause 22 frame, MSB first. For a read it releases the line and shifts the PHY's 16 data bits in. While the frame is on the wire, a busy flag in the command register stays at 1. When busy drops, a read result is already held in the read-data register.

MDC is made from the system clock. Each MDC half period lasts `DIV_HALF` system clocks, so every transfer takes a fixed `128*DIV_HALF` cycles. The line driver is split into a data output and an output enable, so a pad cell outside the block can build the tri-state buffer. Only Clause 22 framing is generated.

Top module: `mgmt_serial_master`

## Requirements
- R1: After reset, the command register (offset 0x50) reads 0, the read-data register (offset 0x4C) reads 0, `mdc` is low and `mdio_oe` is low.
- R2: Offset 0x44 holds the PHY address in bits 12:8 and the register number in bits 4:0. Offset 0x48 holds the write data in bits 15:0. Both read back with all other bits 0.
- R3: A bus write to offset 0x50 with bit 8 set starts a transfer when the block is idle. Bit 0 selects the operation: 0 means read and 1 means write. A command write with bit 8 clear starts nothing.
- R4: Bit 16 of offset 0x50 reads 1 from the first cycle after the starting write. It stays 1 for exactly `128*DIV_HALF` cycles and then reads 0.
- R5: The frame, sampled on MDC rising edges, is 32 ones, start bits 01, opcode (10 for a read, 01 for a write), 5-bit PHY address, 5-bit register number, a 2-bit turnaround, then 16 data bits, each field MSB first. A write drives turnaround 10 followed by the write data.
- R6: MDC is low while idle. During a transfer it toggles every `DIV_HALF` clocks. `mdio_o` changes only as MDC falls, apart from the first bit, which is set up at start while MDC is low.
- R7: For a read, `mdio_oe` is low from the first turnaround bit (bit 46 of the frame) to the end. `mdio_i` is sampled on MDC rising edges, and the 16 sampled bits, first one as MSB, appear at offset 0x4C in the cycle busy clears.
- R8: A start request while busy is ignored and does not lengthen the transfer. The frame uses the address and data values held at start, so register writes during a transfer do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register bus byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_i | input | 1 | Serial data in from the MDIO pad |

## Verification
Busy is due on the first sample after the starting write and drops exactly `128*DIV_HALF` cycles later. The bench counts clock cycles from the start write and checks busy on both sides of that boundary. A read result is checked at the first sample where busy reads 0, not later. Each frame is due at the 64th MDC rising edge after start: a monitor collects bits and enables on MDC rising edges and compares the whole frame against the item the driver queued. A cycle counter checks that each MDC period is `2*DIV_HALF` clocks.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;

  localparam logic [7:0] OFS_ADDR = 8'h44;
  localparam logic [7:0] OFS_WDAT = 8'h48;
  localparam logic [7:0] OFS_RDAT = 8'h4C;
  localparam logic [7:0] OFS_CMD  = 8'h50;

  localparam int CMD_GO_BIT   = 8;
  localparam int CMD_OP_BIT   = 0;
  localparam int CMD_BUSY_BIT = 16;

  typedef struct packed {
    logic        is_write;
    logic [4:0]  phy;
    logic [4:0]  regnum;
    logic [15:0] wdata;
  } xfer_req_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(input xfer_req_t r);
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] dat;
    op  = r.is_write ? 2'b01 : 2'b10;
    ta  = r.is_write ? 2'b10 : 2'b11;
    dat = r.is_write ? r.wdata : 16'hFFFF;
    return {32'hFFFF_FFFF, 2'b01, op, r.phy, r.regnum, ta, dat};
  endfunction

endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          mdc_q, mdc_n;
  logic          term;

  assign term = run && (cnt_q == LAST);
  assign rise = term && !mdc_q;
  assign fall = term && mdc_q;
  assign mdc  = mdc_q;

  always_comb begin
    cnt_n = cnt_q;
    mdc_n = mdc_q;
    if (!run) begin
      cnt_n = '0;
      mdc_n = 1'b0;
    end else if (term) begin
      cnt_n = '0;
      mdc_n = !mdc_q;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
    end
  end
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  xfer_req_t   req,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_done,
  output logic [15:0] rd_data
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_I = IW'(FRAME_BITS - 1);
  localparam logic [IW-1:0] TA_I   = IW'(TA_IDX);
  localparam logic [IW-1:0] DAT_I  = IW'(DATA_IDX);

  logic                  busy_q, busy_n;
  logic                  wr_q, wr_n;
  logic [IW-1:0]         idx_q, idx_n;
  logic [FRAME_BITS-1:0] sh_q, sh_n;
  logic [15:0]           cap_q, cap_n;
  logic                  load_en, cap_en, adv_en, end_en;

  assign load_en = !busy_q && start;
  assign cap_en  = busy_q && rise && !wr_q && (idx_q >= DAT_I);
  assign end_en  = busy_q && fall && (idx_q == LAST_I);
  assign adv_en  = busy_q && fall && (idx_q != LAST_I);

  always_comb begin
    busy_n = busy_q;
    wr_n   = wr_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    cap_n  = cap_q;
    if (load_en) begin
      busy_n = 1'b1;
      wr_n   = req.is_write;
      idx_n  = '0;
      sh_n   = build_frame(req);
    end
    if (cap_en) cap_n = {cap_q[14:0], mdio_i};
    if (adv_en) begin
      idx_n = idx_q + 1'b1;
      sh_n  = {sh_q[FRAME_BITS-2:0], 1'b0};
    end
    if (end_en) busy_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_n;
      wr_q   <= wr_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      cap_q  <= cap_n;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = busy_q && sh_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && (wr_q || (idx_q < TA_I));
  assign rd_done = end_en && !wr_q;
  assign rd_data = cap_q;
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
  import mgmt_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(OFS_ADDR);
  localparam logic [ADDR_W-1:0] A_WDAT = ADDR_W'(OFS_WDAT);
  localparam logic [ADDR_W-1:0] A_RDAT = ADDR_W'(OFS_RDAT);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);

  logic [4:0]  phy_q, phy_n;
  logic [4:0]  rno_q, rno_n;
  logic [15:0] wd_q, wd_n;
  logic [15:0] rd_q, rd_n;
  logic        addr_we, wdat_we, go;
  logic        busy, rise, fall, rd_done;
  logic [15:0] rd_data;
  xfer_req_t   req;
  logic        wdata_unused;

  assign wdata_unused = ^{reg_wdata[31:16], reg_wdata[7:5]};

  assign addr_we = reg_wr && (reg_addr == A_ADDR);
  assign wdat_we = reg_wr && (reg_addr == A_WDAT);
  assign go      = reg_wr && (reg_addr == A_CMD) && reg_wdata[CMD_GO_BIT];

  assign req.is_write = reg_wdata[CMD_OP_BIT];
  assign req.phy      = phy_q;
  assign req.regnum   = rno_q;
  assign req.wdata    = wd_q;

  always_comb begin
    phy_n = phy_q;
    rno_n = rno_q;
    wd_n  = wd_q;
    rd_n  = rd_q;
    if (addr_we) begin
      phy_n = reg_wdata[12:8];
      rno_n = reg_wdata[4:0];
    end
    if (wdat_we) wd_n = reg_wdata[15:0];
    if (rd_done) rd_n = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_q <= '0;
      rno_q <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
    end else begin
      phy_q <= phy_n;
      rno_q <= rno_n;
      wd_q  <= wd_n;
      rd_q  <= rd_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ADDR: reg_rdata = {19'b0, phy_q, 3'b0, rno_q};
      A_WDAT: reg_rdata = {16'b0, wd_q};
      A_RDAT: reg_rdata = {16'b0, rd_q};
      A_CMD:  reg_rdata = 32'(busy) << CMD_BUSY_BIT;
      default: reg_rdata = '0;
    endcase
  end

  mgmt_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .mdc   (mdc),
    .rise  (rise),
    .fall  (fall)
  );

  mgmt_frame_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (go),
    .req     (req),
    .rise    (rise),
    .fall    (fall),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rd_done (rd_done),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/mgmt_serial_master_chk.sv
module mgmt_serial_master_chk
  import mgmt_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int ADDR_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata
);
  localparam logic [31:0] FRAME_CYC = 32'(2 * FRAME_BITS * DIV_HALF);

  logic [31:0] blen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blen <= '0;
    else        blen <= busy ? blen + 1'b1 : '0;
  end

  p_start_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && reg_addr == ADDR_W'(OFS_CMD) && reg_wdata[CMD_GO_BIT]) |=> busy);

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen == FRAME_CYC));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  p_mdio_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

  p_oe_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
endmodule

bind mgmt_serial_master mgmt_serial_master_chk #(
  .DIV_HALF (DIV_HALF),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata)
);

// File: tb/test_mgmt_serial_master.sv
`timescale 1ns/1ps
module test_mgmt_serial_master;
  localparam int DIV       = 4;
  localparam int FRAME_CYC = 128 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int bitcnt = 0;
  int frames_seen = 0;
  int frames_sent = 0;
  int mdc_bad = 0;
  int last_rise = -1;
  bit finished = 0;
  logic [15:0] resp = 16'h0;
  logic [63:0] cap_bits, cap_drv;

  typedef struct {
    logic [63:0] bits;
    logic [63:0] drv;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  mgmt_serial_master #(.DIV_HALF(DIV), .ADDR_W(8)) i_mgmt_serial_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = (bitcnt >= 48 && bitcnt < 64) ? resp[63 - bitcnt] : 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: collects one frame per 64 MDC rising edges and scores it (R5, R7).
  always @(posedge mdc) begin
    if (bitcnt != 0 && (cyc - last_rise) != 2 * DIV) mdc_bad++;
    last_rise = cyc;
    cap_bits[63 - bitcnt] = mdio_o;
    cap_drv[63 - bitcnt]  = mdio_oe;
    bitcnt++;
    if (bitcnt == 64) begin
      exp_t e;
      bitcnt = 0;
      frames_seen++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected frame actual %h expected none", cap_bits);
      end else begin
        e = exp_q.pop_front();
        if (cap_drv !== e.drv) begin
          errors++;
          $display("FAIL R7 drive mask actual %h expected %h", cap_drv, e.drv);
        end else if ((cap_bits & e.drv) !== e.bits) begin
          errors++;
          $display("FAIL R5 frame actual %h expected %h", cap_bits & e.drv, e.bits);
        end
      end
    end
  end

  always @(mdio_o) if (mdc && rst_n) mdc_bad++;

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Driver: sets up registers, queues the expected frame, starts the transfer.
  task automatic launch(input bit wr, input logic [4:0] phy, input logic [4:0] rn,
                        input logic [15:0] wd, input logic [15:0] rsp, output int t0);
    exp_t e;
    bus_wr(8'h44, {19'b0, phy, 3'b0, rn});
    bus_wr(8'h48, {16'b0, wd});
    resp = rsp;
    e.bits = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rn,
              (wr ? 2'b10 : 2'b00), (wr ? wd : 16'h0)};
    e.drv  = wr ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'b0};
    exp_q.push_back(e);
    frames_sent++;
    bus_wr(8'h50, 32'h100 | 32'(wr));
    t0 = cyc;
  endtask

  task automatic wait_idle(input int t0, input string req);
    logic [31:0] v;
    bus_rd(8'h50, v);
    while (v[16]) begin
      @(negedge clk);
      bus_rd(8'h50, v);
    end
    chk(req, 32'(cyc - t0), 32'(FRAME_CYC));
  endtask

  initial begin
    logic [31:0] v;
    int t0;
    repeat (3) @(negedge clk);
    // R1: reset state
    bus_rd(8'h50, v); chk("R1 cmd", v, 32'h0);
    bus_rd(8'h4C, v); chk("R1 rdata", v, 32'h0);
    chk("R1 mdc", 32'(mdc), 32'h0);
    chk("R1 oe", 32'(mdio_oe), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: register readback and field masking
    bus_wr(8'h44, 32'hFFFF_FFFF); bus_rd(8'h44, v); chk("R2 addr mask", v, 32'h0000_1F1F);
    bus_wr(8'h44, 32'h0000_1B0D); bus_rd(8'h44, v); chk("R2 addr", v, 32'h0000_1B0D);
    bus_wr(8'h48, 32'h5555_BEEF); bus_rd(8'h48, v); chk("R2 wdata", v, 32'h0000_BEEF);

    // R3: command without bit 8 starts nothing
    bus_wr(8'h50, 32'h0000_0001);
    bus_rd(8'h50, v); chk("R3 no start", v, 32'h0);
    repeat (3 * DIV) @(negedge clk);
    chk("R3 no mdc", 32'(mdc), 32'h0);

    // R4: exact busy window on a write transfer (frame scored as R5)
    launch(1'b1, 5'h1B, 5'h0D, 16'hBEEF, 16'h0, t0);
    bus_rd(8'h50, v); chk("R4 busy first", v, 32'h0001_0000);
    repeat (FRAME_CYC - 1) @(negedge clk);
    bus_rd(8'h50, v); chk("R4 busy last", v, 32'h0001_0000);
    @(negedge clk);
    bus_rd(8'h50, v); chk("R4 busy clear", v, 32'h0);

    // R7: read data valid when busy clears, three patterns
    launch(1'b0, 5'h05, 5'h02, 16'h0, 16'hA5C3, t0);
    wait_idle(t0, "R4 read len");
    bus_rd(8'h4C, v); chk("R7 rdata A5C3", v, 32'h0000_A5C3);
    launch(1'b0, 5'h00, 5'h1F, 16'h0, 16'h0000, t0);
    wait_idle(t0, "R4 read len");
    bus_rd(8'h4C, v); chk("R7 rdata 0000", v, 32'h0);
    launch(1'b0, 5'h1F, 5'h00, 16'h0, 16'hFFFF, t0);
    wait_idle(t0, "R4 read len");
    bus_rd(8'h4C, v); chk("R7 rdata FFFF", v, 32'h0000_FFFF);

    // R8: start and register writes during busy have no effect on the frame
    launch(1'b1, 5'h1F, 5'h00, 16'h8001, 16'h0, t0);
    repeat (40) @(negedge clk);
    bus_wr(8'h44, 32'h0000_0305);
    bus_wr(8'h48, 32'h0000_1234);
    bus_wr(8'h50, 32'h0000_0100);
    wait_idle(t0, "R8 length");
    bus_rd(8'h44, v); chk("R8 addr reg written", v, 32'h0000_0305);
    bus_rd(8'h4C, v); chk("R8 rdata kept", v, 32'h0000_FFFF);
    repeat (2 * FRAME_CYC) @(negedge clk);
    chk("R8 frame count", 32'(frames_seen), 32'(frames_sent));
    chk("R8 queue empty", 32'(exp_q.size()), 32'h0);
    chk("R6 mdc timing", 32'(mdc_bad), 32'h0);
    chk("R6 idle mdc", 32'(mdc), 32'h0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule